// File: doc/BRIEF.md
# Preloaded Up/Down Timer Time-Base

This block is the time base of a general-purpose timer. A 16-bit counter advances once per prescaled clock tick and runs between zero and a programmable period limit. It can count up, count down, or bounce between the limit and zero (center-aligned). The prescaler divides the enabled clock by its programmed value plus one.

Software reaches three values through a simple write/read port: the counter itself, the prescaler divisor and the period limit. It may write them at any moment, even while the counter runs. The divisor and the period limit each have a preload copy and an active copy. The active divisor is refreshed only on an update event. The active period limit is refreshed either on an update event or on the write itself, as an input selects.

An update event occurs at every wrap, reload or turning point, or when software requests one. It appears as a one-cycle pulse on the output, in the same cycle in which the counter shows its new value. Other logic can use that pulse as an interrupt, DMA or trigger source.

Top module: `updn_timebase`

## Requirements
- R1: After reset the counter reads 0, `update_evt` and `count_down` are 0, the prescaler preload reads 0 and the period preload reads 16'hFFFF.
- R2: The counter changes only on a prescaler tick. A tick occurs on the (P+1)-th cycle with `clk_en` high, where P is the active divisor. Cycles with `clk_en` low neither advance the prescaler nor the counter.
- R3: With `cnt_mode` = 0 (up), the counter steps 0,1,...,A, where A is the active period. On the tick after A it returns to 0 and `update_evt` pulses in the cycle that shows 0. A counter above A also returns to 0 on its next tick.
- R4: With `cnt_mode` = 1 (down), the counter steps down to 0. On the tick after 0 it reloads the period preload value and pulses `update_evt`. `count_down` is 1 in this mode.
- R5: With `cnt_mode` = 2 (center), the counter rises to A, then falls to 0, and repeats. On reaching A, the next tick turns the counter around and loads A-1. On reaching 0, the next tick turns it around and loads 1. Every turn pulses `update_evt` and flips `count_down` (1 while falling).
- R6: With `reload_buf_en` = 1, a period write (`wr_sel` = 2) changes the preload copy only. The counter keeps using the old period until the next update event. A read with `rd_sel` = 2 returns the written value in the cycle after the write.
- R7: With `reload_buf_en` = 0, a period write becomes the active period at once.
- R8: A divisor write (`wr_sel` = 1) always reaches the active divisor only at the next update event.
- R9: A high `sw_update` gives an update event: `update_evt` pulses in the next cycle and both preload copies move to the active copies. The prescaler restarts and the counter loads either 0 or the period preload value. It loads 0 when counting up (up mode, or center while rising) and the period preload value otherwise. This request wins over a counter write and over a tick.
- R10: While the active period is 0, each tick puts the counter at 0 and no automatic update event occurs.
- R11: A counter write (`wr_sel` = 0) loads `wr_data` into the counter at the next edge and suppresses that cycle's tick step. A read with `rd_sel` = 0 returns the counter; `rd_sel` = 1 returns the divisor preload and `rd_sel` = 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable feeding the prescaler |
| cnt_mode | input | 2 | Counting mode: 0 up, 1 down, 2 center (3 acts as up) |
| reload_buf_en | input | 1 | 1: period writes wait for an update event |
| sw_update | input | 1 | Software update-event request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 divisor, 2 period |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read source: 0 counter, 1 divisor preload, 2 period preload |
| rd_data | output | 16 | Read data (combinational) |
| count | output | 16 | Counter value |
| count_down | output | 1 | 1 while counting down |
| update_evt | output | 1 | One-cycle update-event pulse |

## Verification
The bench targets several corner cases, each with a visible symptom:
- Period write while buffering is on: a design that applied it at once would wrap early.
- Divisor write: a design that honoured it before the next event would change the tick spacing mid-period.
- Center-mode turn: a design that turned one count late would step to A+1 or wrap below 0.
- Software request while falling: one that ignored the direction would load 0 where the period belongs.
- Period of 0: a wrong design would keep pulsing `update_evt`.
- Counter written above the period: it must wrap on the next tick rather than run on towards 16'hFFFF.
- Gated `clk_en` patterns: a prescaler that counted disabled cycles would tick too often.

// File: rtl/updn_tb_pkg.sv
`timescale 1ns/1ps
package updn_tb_pkg;

    localparam int unsigned DEF_CNT_W = 16;
    localparam int unsigned DEF_PSC_W = 16;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_CENTER = 2'd2,
        MODE_SPARE  = 2'd3
    } count_mode_e;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_DIV    = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // True when the counter is currently moving towards larger values.
    function automatic logic heading_up(count_mode_e mode, logic falling);
        return (mode == MODE_DOWN) ? 1'b0 :
               (mode == MODE_CENTER) ? !falling : 1'b1;
    endfunction

endpackage

// File: rtl/updn_tb_prescaler.sv
`timescale 1ns/1ps
module updn_tb_prescaler #(
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             restart,
    input  logic [PSC_W-1:0] divisor,
    output logic             tick
);
    logic [PSC_W-1:0] div_q;

    assign tick = clk_en && (div_q == divisor);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (restart || tick) begin
            div_q <= '0;
        end else if (clk_en) begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/updn_tb_shadow.sv
`timescale 1ns/1ps
module updn_tb_shadow
    import updn_tb_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PSC_W  = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              buffered,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  per_pre,
    output logic [CNT_W-1:0]  per_act,
    output logic [CNT_W-1:0]  per_next,
    output logic [PSC_W-1:0]  div_pre,
    output logic [PSC_W-1:0]  div_act
);
    logic             per_wr;
    logic             div_wr;
    logic [PSC_W-1:0] div_next;

    assign per_wr   = wr_en && (wr_sel == SEL_PERIOD);
    assign div_wr   = wr_en && (wr_sel == SEL_DIV);
    assign per_next = per_wr ? wr_data[CNT_W-1:0] : per_pre;
    assign div_next = div_wr ? wr_data[PSC_W-1:0] : div_pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_pre <= '1;
            per_act <= '1;
            div_pre <= '0;
            div_act <= '0;
        end else begin
            per_pre <= per_next;
            div_pre <= div_next;
            if (load) begin
                per_act <= per_next;
                div_act <= div_next;
            end else if (per_wr && !buffered) begin
                per_act <= wr_data[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/updn_tb_counter.sv
`timescale 1ns/1ps
module updn_tb_counter
    import updn_tb_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  count_mode_e      mode,
    input  logic [CNT_W-1:0] per_act,
    input  logic [CNT_W-1:0] per_next,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             sw_upd,
    output logic [CNT_W-1:0] cnt,
    output logic             falling,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d;
    logic             fall_q;
    logic             fall_d;

    always_comb begin
        cnt_d  = cnt;
        fall_d = fall_q;
        wrap   = 1'b0;
        if (sw_upd) begin
            cnt_d = heading_up(mode, fall_q) ? '0 : per_next;
        end else if (cnt_wr) begin
            cnt_d = cnt_wdata;
        end else if (tick) begin
            if (per_act == '0) begin
                cnt_d = '0;
            end else begin
                case (mode)
                    MODE_DOWN: begin
                        if (cnt == '0) begin
                            cnt_d = per_next;
                            wrap  = 1'b1;
                        end else begin
                            cnt_d = cnt - ONE;
                        end
                    end
                    MODE_CENTER: begin
                        if (!fall_q) begin
                            if (cnt >= per_act) begin
                                cnt_d  = per_act - ONE;
                                fall_d = 1'b1;
                                wrap   = 1'b1;
                            end else begin
                                cnt_d = cnt + ONE;
                            end
                        end else begin
                            if (cnt == '0) begin
                                cnt_d  = ONE;
                                fall_d = 1'b0;
                                wrap   = 1'b1;
                            end else begin
                                cnt_d = cnt - ONE;
                            end
                        end
                    end
                    default: begin
                        if (cnt >= per_act) begin
                            cnt_d = '0;
                            wrap  = 1'b1;
                        end else begin
                            cnt_d = cnt + ONE;
                        end
                    end
                endcase
            end
        end
        if (mode != MODE_CENTER) begin
            fall_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            fall_q <= 1'b0;
        end else begin
            cnt    <= cnt_d;
            fall_q <= fall_d;
        end
    end

    assign falling = !heading_up(mode, fall_q);
endmodule

// File: rtl/updn_timebase.sv
`timescale 1ns/1ps
module updn_timebase
    import updn_tb_pkg::*;
#(
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned PSC_W  = DEF_PSC_W,
    parameter int unsigned DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic [1:0]        cnt_mode,
    input  logic              reload_buf_en,
    input  logic              sw_update,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              count_down,
    output logic              update_evt
);
    count_mode_e      mode;
    reg_sel_e         wsel;
    reg_sel_e         rsel;
    logic             tick;
    logic             wrap;
    logic             uev;
    logic             cnt_wr;
    logic [CNT_W-1:0] per_pre;
    logic [CNT_W-1:0] arr_act;
    logic [CNT_W-1:0] per_next;
    logic [PSC_W-1:0] div_pre;
    logic [PSC_W-1:0] div_act;
    logic             upd_q;

    assign mode   = count_mode_e'(cnt_mode);
    assign wsel   = reg_sel_e'(wr_sel);
    assign rsel   = reg_sel_e'(rd_sel);
    assign cnt_wr = wr_en && (wsel == SEL_COUNT);
    assign uev    = sw_update || wrap;

    updn_tb_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .clk_en  (clk_en),
        .restart (uev),
        .divisor (div_act),
        .tick    (tick)
    );

    updn_tb_shadow #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .load     (uev),
        .buffered (reload_buf_en),
        .wr_en    (wr_en),
        .wr_sel   (wsel),
        .wr_data  (wr_data),
        .per_pre  (per_pre),
        .per_act  (arr_act),
        .per_next (per_next),
        .div_pre  (div_pre),
        .div_act  (div_act)
    );

    updn_tb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (mode),
        .per_act   (arr_act),
        .per_next  (per_next),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (wr_data[CNT_W-1:0]),
        .sw_upd    (sw_update),
        .cnt       (count),
        .falling   (count_down),
        .wrap      (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_q <= 1'b0;
        end else begin
            upd_q <= uev;
        end
    end
    assign update_evt = upd_q;

    always_comb begin
        case (rsel)
            SEL_COUNT:  rd_data = DATA_W'(count);
            SEL_DIV:    rd_data = DATA_W'(div_pre);
            SEL_PERIOD: rd_data = DATA_W'(per_pre);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/updn_tb_checker.sv
`timescale 1ns/1ps
module updn_tb_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             clk_en,
    input logic [1:0]       mode,
    input logic             sw_update,
    input logic             wr_en,
    input logic [CNT_W-1:0] count,
    input logic             count_down,
    input logic             update_evt,
    input logic [CNT_W-1:0] arr_act
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assert_freeze_R2: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && !sw_update && !wr_en) |=> $stable(count));

    assert_up_step_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && !sw_update && !wr_en) |=>
        (count == $past(count) || count == $past(count) + ONE || count == '0));

    assert_up_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (update_evt && mode == 2'd0 && $past(mode) == 2'd0) |-> (count == '0));

    assert_down_reload_R4: assert property (@(posedge clk) disable iff (rst)
        (update_evt && mode == 2'd1 && $past(mode) == 2'd1) |-> (count == arr_act));

    assert_center_turn_R5: assert property (@(posedge clk) disable iff (rst)
        (update_evt && mode == 2'd2 && $past(mode) == 2'd2 && !$past(sw_update))
        |-> (count_down != $past(count_down)));

    assert_sw_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        sw_update |=> update_evt);

    assert_zero_period_R10: assert property (@(posedge clk) disable iff (rst)
        (arr_act == '0 && !sw_update) |=> !update_evt);
endmodule

bind updn_timebase updn_tb_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .mode       (cnt_mode),
    .sw_update  (sw_update),
    .wr_en      (wr_en),
    .count      (count),
    .count_down (count_down),
    .update_evt (update_evt),
    .arr_act    (arr_act)
);

// File: tb/updn_timebase_bench.sv
`timescale 1ns/1ps
module updn_timebase_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b1;
    logic [1:0]  cnt_mode = 2'd0;
    logic        reload_buf_en = 1'b1;
    logic        sw_update = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic [15:0] count;
    logic        count_down;
    logic        update_evt;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    logic [15:0] m_cnt, m_pcnt, m_psc_pre, m_psc_act, m_arr_pre, m_arr_act;
    logic        m_fall, m_upd;

    always #2 clk = ~clk;

    updn_timebase u_updn_timebase (
        .clk(clk), .rst(rst), .clk_en(clk_en), .cnt_mode(cnt_mode),
        .reload_buf_en(reload_buf_en), .sw_update(sw_update), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .count(count), .count_down(count_down), .update_evt(update_evt)
    );

    task automatic check(string req, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        logic        tick, ev, up, per_w, div_w;
        logic [15:0] arr_nx, psc_nx;
        if (rst) begin
            m_cnt = 0; m_pcnt = 0; m_psc_pre = 0; m_psc_act = 0;
            m_arr_pre = 16'hFFFF; m_arr_act = 16'hFFFF; m_fall = 0; m_upd = 0;
        end else begin
            tick   = clk_en && (m_pcnt == m_psc_act);
            per_w  = wr_en && wr_sel == 2'd2;
            div_w  = wr_en && wr_sel == 2'd1;
            arr_nx = per_w ? wr_data : m_arr_pre;
            psc_nx = div_w ? wr_data : m_psc_pre;
            up     = (cnt_mode == 2'd1) ? 1'b0 : (cnt_mode == 2'd2) ? !m_fall : 1'b1;
            ev     = 0;
            if (sw_update) begin
                ev = 1;
                m_cnt = up ? 16'd0 : arr_nx;
            end else if (wr_en && wr_sel == 2'd0) begin
                m_cnt = wr_data;
            end else if (tick) begin
                if (m_arr_act == 0) m_cnt = 0;
                else if (cnt_mode == 2'd1) begin
                    if (m_cnt == 0) begin m_cnt = arr_nx; ev = 1; end
                    else m_cnt = m_cnt - 1;
                end else if (cnt_mode == 2'd2) begin
                    if (!m_fall) begin
                        if (m_cnt >= m_arr_act) begin m_cnt = m_arr_act - 1; m_fall = 1; ev = 1; end
                        else m_cnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin m_cnt = 1; m_fall = 0; ev = 1; end
                        else m_cnt = m_cnt - 1;
                    end
                end else begin
                    if (m_cnt >= m_arr_act) begin m_cnt = 0; ev = 1; end
                    else m_cnt = m_cnt + 1;
                end
            end
            if (cnt_mode != 2'd2) m_fall = 0;
            if (ev || tick) m_pcnt = 0;
            else if (clk_en) m_pcnt = m_pcnt + 1;
            if (ev) begin
                m_arr_act = arr_nx; m_psc_act = psc_nx;
            end else if (per_w && !reload_buf_en) begin
                m_arr_act = wr_data;
            end
            m_arr_pre = arr_nx;
            m_psc_pre = psc_nx;
            m_upd = ev;
        end
    end

    // compare against the model midway through every cycle
    always @(negedge clk) begin
        int exp_rd;
        if (!rst && !done) begin
            exp_rd = (rd_sel == 2'd0) ? int'(m_cnt) : (rd_sel == 2'd1) ? int'(m_psc_pre) :
                     (rd_sel == 2'd2) ? int'(m_arr_pre) : 0;
            check(cur_req, "count", int'(count), int'(m_cnt));
            check(cur_req, "update_evt", int'(update_evt), int'(m_upd));
            check(cur_req, "count_down", int'(count_down),
                  int'(cnt_mode == 2'd1 || (cnt_mode == 2'd2 && m_fall)));
            check(cur_req, "rd_data", int'(rd_data), exp_rd);
        end
    end

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rd_sel = rd_sel + 2'd1;
        end
    endtask

    task automatic write_reg(logic [1:0] sel, logic [15:0] data);
        @(posedge clk); #1;
        wr_en = 1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic soft_update();
        @(posedge clk); #1;
        sw_update = 1;
        @(posedge clk); #1;
        sw_update = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        run(4);
        rst = 0;
        rd_sel = 2'd2; #0.3;
        check("R1", "reset period preload", int'(rd_data), 16'hFFFF);
        rd_sel = 2'd1; #0.3;
        check("R1", "reset divisor preload", int'(rd_data), 0);
        check("R1", "reset count", int'(count), 0);
        check("R1", "reset update_evt", int'(update_evt), 0);
        check("R1", "reset count_down", int'(count_down), 0);

        cur_req = "R3";
        write_reg(2'd2, 16'd5);
        write_reg(2'd1, 16'd0);
        soft_update();
        run(20);

        cur_req = "R2";
        write_reg(2'd1, 16'd2);
        soft_update();
        run(25);
        for (int i = 0; i < 24; i++) begin
            @(posedge clk); #1;
            clk_en = (i % 3) != 0;
        end
        clk_en = 1;

        cur_req = "R4";
        cnt_mode = 2'd1;
        soft_update();
        run(25);

        cur_req = "R5";
        cnt_mode = 2'd2;
        write_reg(2'd1, 16'd0);
        soft_update();
        run(25);

        cur_req = "R6";
        reload_buf_en = 1;
        write_reg(2'd2, 16'd3);
        rd_sel = 2'd2; #0.3;
        check("R6", "period read back", int'(rd_data), 3);
        run(25);

        cur_req = "R7";
        reload_buf_en = 0;
        write_reg(2'd2, 16'd7);
        run(30);

        cur_req = "R8";
        write_reg(2'd1, 16'd1);
        run(30);

        cur_req = "R9";
        run(5);
        soft_update();
        run(3);
        cnt_mode = 2'd1;
        soft_update();
        check("R9", "down request count", int'(count), 7);
        check("R9", "down request pulse", int'(update_evt), 1);
        cnt_mode = 2'd0;
        soft_update();
        check("R9", "up request count", int'(count), 0);
        run(12);

        cur_req = "R10";
        write_reg(2'd2, 16'd0);
        begin
            int pulses = 0;
            for (int i = 0; i < 20; i++) begin
                @(posedge clk); #1;
                if (update_evt) pulses++;
            end
            check("R10", "pulses with zero period", pulses, 0);
            check("R10", "count held", int'(count), 0);
        end
        soft_update();
        run(6);

        cur_req = "R11";
        write_reg(2'd2, 16'd9);
        write_reg(2'd0, 16'd4);
        check("R11", "written count", int'(count), 4);
        rd_sel = 2'd3; #0.3;
        check("R11", "spare read", int'(rd_data), 0);
        run(8);
        write_reg(2'd0, 16'd12);
        run(20);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule